// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the status of each hardware thread in an out-of-order fetch stage. In every cycle it takes block and unblock strobes from the four downstream stages, a context-switch flag, squash requests with redirect targets from commit and from decode, and a flag saying the reorder buffer is still squashing. It also takes a per-thread event code from the fetch datapath: cache request issued, rejected or retried, response returned, resume, translation fault or quiesce. From these it keeps four sticky stall flags per thread, moves the thread status through a fixed priority chain, and reloads the thread's program counter, next program counter and micro-PC on a squash.

A separate combinational slice decides whether the instruction now being placed in a fetch group closes that group. The fetch datapath consumes the per-thread status and redirect state. Each cycle, the `status_chg_o` output tells it whether the control signals forced any thread to change status.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Each thread has one sticky stall flag per stage, with bit 0 = decode, 1 = rename, 2 = execute and 3 = commit. A block strobe sets the flag at the next edge and an unblock strobe clears it. The block and unblock strobes for the same stage and thread are never high together.
- R2: `stalled_o[t]` is high in the same cycle when the context-switch flag is high, or when any stall flag of thread t is set once this cycle's strobes are applied.
- R3: A commit squash has top priority. At the next edge the thread status becomes squashing (code 1), and the PC, next PC and micro-PC take the commit redirect values.
- R4: If there is no commit squash and the reorder-buffer-squashing flag is high, the thread becomes squashing at the next edge and its PC registers are left unchanged.
- R5: A decode squash redirects the thread as in R3, using the decode values, only when the thread is not already squashing. A thread that is already squashing ignores it, and its PC registers stay unchanged.
- R6: If no squash applies and the thread is stalled, it becomes blocked (code 2). This does not happen while the thread is waiting on a retry (3) or a response (4), nor while it is in trap-pending (6) or quiesce-pending (7).
- R7: A thread that is blocked or squashing returns to running (code 0) at the first edge with no squash, no reorder-buffer squash and no stall.
- R8: `status_chg_o` is high in any cycle in which any thread takes a transition under R3 to R7.
- R9: Event codes are acted on only in cycles in which R3 to R7 do not apply. Code 1 (issue) moves a running (0) or access-complete (5) thread to wait-response. Code 2 (reject) moves such a thread to wait-retry. Code 3 (retry granted) moves wait-retry to wait-response. Code 4 (response) moves wait-response to access-complete, or to blocked if the thread is stalled. A response in any other status is ignored.
- R10: Code 6 (fault) moves a running or access-complete thread to trap-pending. Only a squash (R3, R4 or R5) leaves trap-pending. Code 7 moves such a thread to quiesce-pending. Code 5 (resume) returns quiesce-pending or access-complete to running.
- R11: `grp_end_o` is high when the slot index equals the fetch width minus one, when PC plus the instruction size is aligned to the cache line, or when the next PC differs from PC plus the instruction size.
- R12: During reset every thread is running, its PC equals RESET_PC, its next PC equals RESET_PC plus the instruction size, its micro-PC is 0 and its stall flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_i | input | NT x 4 | Per-thread, per-stage block strobes |
| unblk_i | input | NT x 4 | Per-thread, per-stage unblock strobes |
| ctx_sw_i | input | 1 | Context switch in progress |
| cmt_sq_i | input | NT | Squash from commit |
| cmt_pc_i | input | NT x AW | Commit redirect PC |
| cmt_npc_i | input | NT x AW | Commit redirect next PC |
| cmt_upc_i | input | NT x UW | Commit redirect micro-PC |
| rob_sq_i | input | NT | Reorder buffer still squashing |
| dec_sq_i | input | NT | Squash from decode |
| dec_pc_i | input | NT x AW | Decode redirect PC |
| dec_npc_i | input | NT x AW | Decode redirect next PC |
| dec_upc_i | input | NT x UW | Decode redirect micro-PC |
| evt_i | input | NT x 3 | Fetch-side event code |
| grp_slot_i | input | SLOT_W | Slot index of the current instruction in its group |
| grp_pc_i | input | AW | PC of the current instruction |
| grp_npc_i | input | AW | Next PC of the current instruction |
| status_o | output | NT x 3 | Thread status code |
| pc_o | output | NT x AW | Thread PC |
| npc_o | output | NT x AW | Thread next PC |
| upc_o | output | NT x UW | Thread micro-PC |
| stalled_o | output | NT | Thread stalled this cycle |
| status_chg_o | output | 1 | A control-driven status change occurs this cycle |
| grp_end_o | output | 1 | Current instruction closes its fetch group |

## Verification
`stalled_o`, `status_chg_o` and `grp_end_o` are combinational, so each one is due in the same cycle as the inputs that produce it. The bench drives inputs on the falling edge and compares these outputs 1 ns later, before the next rising edge. Status, PC, next PC, micro-PC and stall flags pass through one register, so they are due after exactly one rising edge. The reference model applies its update at that edge, and the bench compares 1 ns after it.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NUM_STAGES = 4;
  localparam int ST_W = 3;
  localparam int EV_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_RUN     = 3'd0,
    ST_SQUASH  = 3'd1,
    ST_BLOCK   = 3'd2,
    ST_WRETRY  = 3'd3,
    ST_WRESP   = 3'd4,
    ST_ACCDONE = 3'd5,
    ST_TRAP    = 3'd6,
    ST_QUIESCE = 3'd7
  } fsc_st_e;

  typedef enum logic [EV_W-1:0] {
    EV_NONE    = 3'd0,
    EV_ISSUE   = 3'd1,
    EV_REJECT  = 3'd2,
    EV_RETRY   = 3'd3,
    EV_RESP    = 3'd4,
    EV_RESUME  = 3'd5,
    EV_FAULT   = 3'd6,
    EV_QUIESCE = 3'd7
  } fsc_ev_e;
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags
  import fsc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_STAGES-1:0] blk_i,
  input  logic [NUM_STAGES-1:0] unblk_i,
  input  logic                  ctx_sw_i,
  output logic                  stalled_o
);
  logic [NUM_STAGES-1:0] flags_q, flags_d;

  // strobes take effect in the cycle they arrive
  assign flags_d   = (flags_q | blk_i) & ~unblk_i;
  assign stalled_o = ctx_sw_i | (|flags_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   UW         = 4,
  parameter int unsigned   INST_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC   = 'h1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stalled_i,
  input  logic            cmt_sq_i,
  input  logic [AW-1:0]   cmt_pc_i,
  input  logic [AW-1:0]   cmt_npc_i,
  input  logic [UW-1:0]   cmt_upc_i,
  input  logic            rob_sq_i,
  input  logic            dec_sq_i,
  input  logic [AW-1:0]   dec_pc_i,
  input  logic [AW-1:0]   dec_npc_i,
  input  logic [UW-1:0]   dec_upc_i,
  input  logic [EV_W-1:0] evt_i,
  output logic [ST_W-1:0] status_o,
  output logic [AW-1:0]   pc_o,
  output logic [AW-1:0]   npc_o,
  output logic [UW-1:0]   upc_o,
  output logic            chg_o
);
  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  fsc_st_e       st_q, st_d;
  fsc_ev_e       ev;
  logic [AW-1:0] pc_q, npc_q;
  logic [UW-1:0] upc_q;
  logic          redir_cmt, redir_dec;
  logic          exempt, fetching;

  assign ev       = fsc_ev_e'(evt_i);
  assign exempt   = (st_q == ST_WRESP) || (st_q == ST_WRETRY) ||
                    (st_q == ST_TRAP)  || (st_q == ST_QUIESCE);
  assign fetching = (st_q == ST_RUN) || (st_q == ST_ACCDONE);

  always_comb begin
    st_d      = st_q;
    redir_cmt = 1'b0;
    redir_dec = 1'b0;
    chg_o     = 1'b1;
    if (cmt_sq_i) begin
      st_d      = ST_SQUASH;
      redir_cmt = 1'b1;
    end else if (rob_sq_i) begin
      st_d = ST_SQUASH;
    end else if (dec_sq_i && st_q != ST_SQUASH) begin
      st_d      = ST_SQUASH;
      redir_dec = 1'b1;
    end else if (stalled_i && !exempt) begin
      st_d = ST_BLOCK;
    end else if (st_q == ST_BLOCK || st_q == ST_SQUASH) begin
      st_d = ST_RUN;
    end else begin
      chg_o = 1'b0;
      unique case (ev)
        EV_ISSUE:   if (fetching) st_d = ST_WRESP;
        EV_REJECT:  if (fetching) st_d = ST_WRETRY;
        EV_RETRY:   if (st_q == ST_WRETRY) st_d = ST_WRESP;
        EV_RESP:    if (st_q == ST_WRESP) st_d = stalled_i ? ST_BLOCK : ST_ACCDONE;
        EV_RESUME:  if (st_q == ST_ACCDONE || st_q == ST_QUIESCE) st_d = ST_RUN;
        EV_FAULT:   if (fetching) st_d = ST_TRAP;
        EV_QUIESCE: if (fetching) st_d = ST_QUIESCE;
        default:    st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      pc_q  <= RESET_PC;
      npc_q <= RESET_PC + STEP;
      upc_q <= '0;
    end else begin
      st_q <= st_d;
      if (redir_cmt) begin
        pc_q  <= cmt_pc_i;
        npc_q <= cmt_npc_i;
        upc_q <= cmt_upc_i;
      end else if (redir_dec) begin
        pc_q  <= dec_pc_i;
        npc_q <= dec_npc_i;
        upc_q <= dec_upc_i;
      end
    end
  end

  assign status_o = st_q;
  assign pc_o     = pc_q;
  assign npc_o    = npc_q;
  assign upc_o    = upc_q;
endmodule

// File: rtl/fsc_group_end.sv
module fsc_group_end #(
  parameter int unsigned AW          = 32,
  parameter int unsigned INST_BYTES  = 4,
  parameter int unsigned LINE_BYTES  = 32,
  parameter int unsigned FETCH_WIDTH = 4,
  parameter int unsigned SLOT_W      = 2
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     npc_i,
  output logic              end_o
);
  localparam logic [AW-1:0]     LINE_MASK = AW'(LINE_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FETCH_WIDTH - 1);

  logic [AW-1:0] seq_pc;
  logic          width_hit, line_hit, flow_hit;

  assign seq_pc    = pc_i + AW'(INST_BYTES);
  assign width_hit = (slot_i == LAST_SLOT);
  assign line_hit  = ((seq_pc & LINE_MASK) == '0);
  assign flow_hit  = (npc_i != seq_pc);
  assign end_o     = width_hit | line_hit | flow_hit;
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned   NT          = 2,
  parameter int unsigned   AW          = 32,
  parameter int unsigned   UW          = 4,
  parameter int unsigned   INST_BYTES  = 4,
  parameter int unsigned   LINE_BYTES  = 32,
  parameter int unsigned   FETCH_WIDTH = 4,
  parameter logic [AW-1:0] RESET_PC    = 'h1000,
  localparam int unsigned  SLOT_W      = (FETCH_WIDTH > 1) ? $clog2(FETCH_WIDTH) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NT-1:0][NUM_STAGES-1:0]   blk_i,
  input  logic [NT-1:0][NUM_STAGES-1:0]   unblk_i,
  input  logic                            ctx_sw_i,
  input  logic [NT-1:0]                   cmt_sq_i,
  input  logic [NT-1:0][AW-1:0]           cmt_pc_i,
  input  logic [NT-1:0][AW-1:0]           cmt_npc_i,
  input  logic [NT-1:0][UW-1:0]           cmt_upc_i,
  input  logic [NT-1:0]                   rob_sq_i,
  input  logic [NT-1:0]                   dec_sq_i,
  input  logic [NT-1:0][AW-1:0]           dec_pc_i,
  input  logic [NT-1:0][AW-1:0]           dec_npc_i,
  input  logic [NT-1:0][UW-1:0]           dec_upc_i,
  input  logic [NT-1:0][EV_W-1:0]         evt_i,
  input  logic [SLOT_W-1:0]               grp_slot_i,
  input  logic [AW-1:0]                   grp_pc_i,
  input  logic [AW-1:0]                   grp_npc_i,
  output logic [NT-1:0][ST_W-1:0]         status_o,
  output logic [NT-1:0][AW-1:0]           pc_o,
  output logic [NT-1:0][AW-1:0]           npc_o,
  output logic [NT-1:0][UW-1:0]           upc_o,
  output logic [NT-1:0]                   stalled_o,
  output logic                            status_chg_o,
  output logic                            grp_end_o
);
  logic [NT-1:0] chg;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    fsc_stall_flags u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .blk_i     (blk_i[t]),
      .unblk_i   (unblk_i[t]),
      .ctx_sw_i  (ctx_sw_i),
      .stalled_o (stalled_o[t])
    );

    fsc_thread_fsm #(
      .AW(AW), .UW(UW), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)
    ) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stalled_i (stalled_o[t]),
      .cmt_sq_i  (cmt_sq_i[t]),
      .cmt_pc_i  (cmt_pc_i[t]),
      .cmt_npc_i (cmt_npc_i[t]),
      .cmt_upc_i (cmt_upc_i[t]),
      .rob_sq_i  (rob_sq_i[t]),
      .dec_sq_i  (dec_sq_i[t]),
      .dec_pc_i  (dec_pc_i[t]),
      .dec_npc_i (dec_npc_i[t]),
      .dec_upc_i (dec_upc_i[t]),
      .evt_i     (evt_i[t]),
      .status_o  (status_o[t]),
      .pc_o      (pc_o[t]),
      .npc_o     (npc_o[t]),
      .upc_o     (upc_o[t]),
      .chg_o     (chg[t])
    );
  end

  assign status_chg_o = |chg;

  fsc_group_end #(
    .AW(AW), .INST_BYTES(INST_BYTES), .LINE_BYTES(LINE_BYTES),
    .FETCH_WIDTH(FETCH_WIDTH), .SLOT_W(SLOT_W)
  ) u_grp (
    .slot_i (grp_slot_i),
    .pc_i   (grp_pc_i),
    .npc_i  (grp_npc_i),
    .end_o  (grp_end_o)
  );
endmodule

// File: rtl/fetch_status_ctrl_chk.sv
module fetch_status_ctrl_chk
  import fsc_pkg::*;
#(
  parameter int unsigned NT          = 2,
  parameter int unsigned AW          = 32,
  parameter int unsigned FETCH_WIDTH = 4,
  parameter int unsigned SLOT_W      = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NT-1:0][NUM_STAGES-1:0] blk_i,
  input logic [NT-1:0][NUM_STAGES-1:0] unblk_i,
  input logic [NT-1:0]                 cmt_sq_i,
  input logic [NT-1:0][AW-1:0]         cmt_pc_i,
  input logic [NT-1:0]                 rob_sq_i,
  input logic [NT-1:0]                 dec_sq_i,
  input logic [SLOT_W-1:0]             grp_slot_i,
  input logic [NT-1:0][ST_W-1:0]       status_o,
  input logic [NT-1:0][AW-1:0]         pc_o,
  input logic                          status_chg_o,
  input logic                          grp_end_o
);
  for (genvar t = 0; t < NT; t++) begin : g_chk
    // R1
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blk_i[t] & unblk_i[t]) == '0);
    // R3
    cmt_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmt_sq_i[t] |=> (status_o[t] == ST_SQUASH) && (pc_o[t] == $past(cmt_pc_i[t])));
    // R4
    rob_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmt_sq_i[t] && rob_sq_i[t]) |=> (status_o[t] == ST_SQUASH) && $stable(pc_o[t]));
    // R5
    dec_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[t] == ST_SQUASH && dec_sq_i[t] && !cmt_sq_i[t]) |=> $stable(pc_o[t]));
    // R10
    trap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[t] == ST_TRAP && !cmt_sq_i[t] && !rob_sq_i[t] && !dec_sq_i[t])
      |=> status_o[t] == ST_TRAP);
  end

  // R8
  squash_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_sq_i != '0 || rob_sq_i != '0) |-> status_chg_o);
  // R11
  width_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_slot_i == SLOT_W'(FETCH_WIDTH - 1)) |-> grp_end_o);
endmodule

bind fetch_status_ctrl fetch_status_ctrl_chk #(
  .NT(NT), .AW(AW), .FETCH_WIDTH(FETCH_WIDTH), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .blk_i        (blk_i),
  .unblk_i      (unblk_i),
  .cmt_sq_i     (cmt_sq_i),
  .cmt_pc_i     (cmt_pc_i),
  .rob_sq_i     (rob_sq_i),
  .dec_sq_i     (dec_sq_i),
  .grp_slot_i   (grp_slot_i),
  .status_o     (status_o),
  .pc_o         (pc_o),
  .status_chg_o (status_chg_o),
  .grp_end_o    (grp_end_o)
);

// File: tb/fetch_status_ctrl_test.sv
`timescale 1ns/1ps
module fetch_status_ctrl_test;
  localparam int NT = 2;
  localparam logic [31:0] RPC = 32'h1000;

  localparam int S_RUN = 0, S_SQ = 1, S_BLK = 2, S_WRT = 3, S_WRS = 4,
                 S_ACC = 5, S_TRAP = 6, S_QUI = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NT-1:0][3:0]  blk, unblk;
  logic                ctx;
  logic [NT-1:0]       cmt_sq, rob_sq, dec_sq;
  logic [NT-1:0][31:0] cmt_pc, cmt_npc, dec_pc, dec_npc;
  logic [NT-1:0][3:0]  cmt_upc, dec_upc;
  logic [NT-1:0][2:0]  evt;
  logic [1:0]          slot;
  logic [31:0]         gpc, gnpc;

  logic [NT-1:0][2:0]  status;
  logic [NT-1:0][31:0] pc, npc;
  logic [NT-1:0][3:0]  upc;
  logic [NT-1:0]       stalled;
  logic                chg, gend;

  fetch_status_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .blk_i(blk), .unblk_i(unblk), .ctx_sw_i(ctx),
    .cmt_sq_i(cmt_sq), .cmt_pc_i(cmt_pc), .cmt_npc_i(cmt_npc), .cmt_upc_i(cmt_upc),
    .rob_sq_i(rob_sq), .dec_sq_i(dec_sq), .dec_pc_i(dec_pc), .dec_npc_i(dec_npc),
    .dec_upc_i(dec_upc), .evt_i(evt), .grp_slot_i(slot), .grp_pc_i(gpc),
    .grp_npc_i(gnpc), .status_o(status), .pc_o(pc), .npc_o(npc), .upc_o(upc),
    .stalled_o(stalled), .status_chg_o(chg), .grp_end_o(gend)
  );

  int n_chk = 0, n_bad = 0;
  int          m_st  [NT];
  logic [3:0]  m_fl  [NT];
  logic [31:0] m_pc  [NT], m_npc [NT];
  logic [3:0]  m_upc [NT];

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle_inputs();
    blk = '0; unblk = '0; ctx = 1'b0;
    cmt_sq = '0; rob_sq = '0; dec_sq = '0;
    cmt_pc = '0; cmt_npc = '0; cmt_upc = '0;
    dec_pc = '0; dec_npc = '0; dec_upc = '0;
    evt = '0; slot = 2'd0; gpc = 32'h100; gnpc = 32'h104;
  endtask

  task automatic cmp_regs(string tag);
    for (int t = 0; t < NT; t++) begin
      chk(tag, $sformatf("status[%0d]", t), status[t], m_st[t]);
      chk(tag, $sformatf("pc[%0d]", t), pc[t], m_pc[t]);
      chk(tag, $sformatf("npc[%0d]", t), npc[t], m_npc[t]);
      chk(tag, $sformatf("upc[%0d]", t), upc[t], m_upc[t]);
    end
  endtask

  // called just after a falling edge with inputs already set
  task automatic tick(string tag);
    int          nst [NT];
    logic [3:0]  nfl [NT];
    logic [31:0] npc_v [NT], nnpc_v [NT];
    logic [3:0]  nupc_v [NT];
    bit          any_chg, ge;
    logic [31:0] seq;
    #1;
    any_chg = 0;
    for (int t = 0; t < NT; t++) begin
      bit stl, fetching, exempt;
      nfl[t] = (m_fl[t] | blk[t]) & ~unblk[t];
      stl = ctx || (nfl[t] != 4'd0);
      chk(tag, $sformatf("stalled[%0d]", t), stalled[t], stl);
      nst[t] = m_st[t]; npc_v[t] = m_pc[t]; nnpc_v[t] = m_npc[t]; nupc_v[t] = m_upc[t];
      fetching = (m_st[t] == S_RUN) || (m_st[t] == S_ACC);
      exempt = (m_st[t] == S_WRS) || (m_st[t] == S_WRT) || (m_st[t] == S_TRAP) || (m_st[t] == S_QUI);
      if (cmt_sq[t]) begin
        nst[t] = S_SQ; npc_v[t] = cmt_pc[t]; nnpc_v[t] = cmt_npc[t]; nupc_v[t] = cmt_upc[t]; any_chg = 1;
      end else if (rob_sq[t]) begin
        nst[t] = S_SQ; any_chg = 1;
      end else if (dec_sq[t] && m_st[t] != S_SQ) begin
        nst[t] = S_SQ; npc_v[t] = dec_pc[t]; nnpc_v[t] = dec_npc[t]; nupc_v[t] = dec_upc[t]; any_chg = 1;
      end else if (stl && !exempt) begin
        nst[t] = S_BLK; any_chg = 1;
      end else if (m_st[t] == S_BLK || m_st[t] == S_SQ) begin
        nst[t] = S_RUN; any_chg = 1;
      end else begin
        case (int'(evt[t]))
          1: if (fetching) nst[t] = S_WRS;
          2: if (fetching) nst[t] = S_WRT;
          3: if (m_st[t] == S_WRT) nst[t] = S_WRS;
          4: if (m_st[t] == S_WRS) nst[t] = stl ? S_BLK : S_ACC;
          5: if (m_st[t] == S_ACC || m_st[t] == S_QUI) nst[t] = S_RUN;
          6: if (fetching) nst[t] = S_TRAP;
          7: if (fetching) nst[t] = S_QUI;
          default: ;
        endcase
      end
    end
    chk(tag, "status_chg", chg, any_chg);
    seq = gpc + 32'd4;
    ge = (slot == 2'd3) || (seq[4:0] == 5'd0) || (gnpc != seq);
    chk(tag, "grp_end", gend, ge);
    @(posedge clk);
    #1;
    for (int t = 0; t < NT; t++) begin
      m_st[t] = nst[t]; m_fl[t] = nfl[t];
      m_pc[t] = npc_v[t]; m_npc[t] = nnpc_v[t]; m_upc[t] = nupc_v[t];
    end
    cmp_regs(tag);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle_inputs();
    for (int t = 0; t < NT; t++) begin
      m_st[t] = S_RUN; m_fl[t] = 4'd0; m_pc[t] = RPC; m_npc[t] = RPC + 32'd4; m_upc[t] = 4'd0;
    end
    #5;
    // R12 reset state
    cmp_regs("R12");
    chk("R12", "stalled", stalled, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tick("R12");

    // R1/R2: decode block on thread 0 then unblock
    blk[0] = 4'b0001; tick("R2");
    blk = '0; tick("R1");
    unblk[0] = 4'b0001; tick("R7");
    unblk = '0; tick("R7");
    // R2: context switch stalls every thread
    ctx = 1'b1; tick("R2");
    ctx = 1'b0; tick("R7");

    // R3 commit squash on thread 1
    cmt_sq[1] = 1'b1; cmt_pc[1] = 32'h2000; cmt_npc[1] = 32'h2004; cmt_upc[1] = 4'd3;
    tick("R3");
    cmt_sq = '0;
    // R4 rob squashing holds, R5 decode squash ignored while squashing
    rob_sq[1] = 1'b1; tick("R4");
    rob_sq = '0; dec_sq[1] = 1'b1; dec_pc[1] = 32'h3000; dec_npc[1] = 32'h3004; tick("R5");
    dec_sq = '0; tick("R7");
    // R5 decode squash from running redirects
    dec_sq[0] = 1'b1; dec_pc[0] = 32'h4400; dec_npc[0] = 32'h4404; dec_upc[0] = 4'd1; tick("R5");
    dec_sq = '0; tick("R7");
    // R3 over R4/R5 priority
    cmt_sq[0] = 1'b1; rob_sq[0] = 1'b1; dec_sq[0] = 1'b1;
    cmt_pc[0] = 32'h5000; cmt_npc[0] = 32'h5008; dec_pc[0] = 32'h6000; tick("R3");
    idle_inputs(); tick("R7");

    // R9 issue, stall while waiting, response -> blocked
    evt[0] = 3'd1; tick("R9");
    evt[0] = 3'd0; blk[0] = 4'b0100; tick("R6");
    blk = '0; evt[0] = 3'd4; tick("R9");
    evt[0] = 3'd0; unblk[0] = 4'b0100; tick("R7");
    unblk = '0; tick("R7");
    // R9 reject, retry, response -> access complete, resume
    evt[1] = 3'd2; tick("R9");
    evt[1] = 3'd4; tick("R9");
    evt[1] = 3'd3; tick("R9");
    evt[1] = 3'd4; tick("R9");
    evt[1] = 3'd5; tick("R10");
    evt[1] = 3'd0;
    // R10 fault -> trap, sticky through stall and resume, left by decode squash
    evt[0] = 3'd6; tick("R10");
    evt[0] = 3'd5; blk[0] = 4'b1000; tick("R10");
    evt[0] = 3'd0; blk = '0; tick("R6");
    dec_sq[0] = 1'b1; dec_pc[0] = 32'h7000; dec_npc[0] = 32'h7004; tick("R10");
    dec_sq = '0; unblk[0] = 4'b1000; tick("R7");
    unblk = '0;
    // R10 quiesce and resume
    evt[1] = 3'd7; tick("R10");
    evt[1] = 3'd1; tick("R10");
    evt[1] = 3'd5; tick("R10");
    evt[1] = 3'd0;

    // R11 group end cases
    slot = 2'd3; gpc = 32'h100; gnpc = 32'h104; tick("R11");
    slot = 2'd1; gpc = 32'h11c; gnpc = 32'h120; tick("R11");
    slot = 2'd1; gpc = 32'h104; gnpc = 32'h200; tick("R11");
    slot = 2'd2; gpc = 32'h108; gnpc = 32'h10c; tick("R11");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      for (int t = 0; t < NT; t++) begin
        for (int s = 0; s < 4; s++) begin
          blk[t][s] = ($urandom % 12) == 0;
          unblk[t][s] = (($urandom % 6) == 0) && !blk[t][s];
        end
        cmt_sq[t] = ($urandom % 25) == 0;
        rob_sq[t] = ($urandom % 25) == 0;
        dec_sq[t] = ($urandom % 10) == 0;
        cmt_pc[t] = $urandom; cmt_npc[t] = $urandom; cmt_upc[t] = 4'($urandom);
        dec_pc[t] = $urandom; dec_npc[t] = $urandom; dec_upc[t] = 4'($urandom);
        evt[t] = 3'($urandom);
      end
      ctx = ($urandom % 30) == 0;
      slot = 2'($urandom);
      gpc = $urandom & 32'hffff_fffc;
      gnpc = (($urandom % 3) == 0) ? $urandom : gpc + 32'd4;
      tick("R8");
    end
    idle_inputs();
    tick("R7");
    summary();
  end
endmodule